// File: doc/BRIEF.md
# Configurable-Width Read Lane Steering

This block sits between the wide read bus of a memory core and the logic that drives the external data lanes. The core presents a bus of sets, one set per output lane at full width. Each set carries the bits for every time slot of one read packet. A 3-bit width code chooses how many low-numbered lanes are active: 1, 2, 4, 8 or 16. A sub-column address then picks which aligned group of core sets is steered down onto those lanes.

The sub-column address extends the column address at its low end. The width code decides how many of its low bits are dropped. In xN mode the low log2(N) bits are ignored, and the remaining bits choose the group. The lanes above the active width output zero, and a per-lane enable vector marks the active ones. Results are registered one cycle after a read strobe and carry their own valid flag. A width code outside the legal set still gives a usable x16 result and raises an error flag alongside the data.

Top module: `rdlane_steer`

## Requirements
- R1: After reset is asserted, `out_vld_o`, `width_err_o`, `lane_en_o` and `lane_data_o` are all zero.
- R2: Width codes 3'b000, 3'b001, 3'b010, 3'b011 and 3'b100 select x1, x2, x4, x8 and x16. The registered `lane_en_o` has bits [N-1:0] set and all higher bits clear.
- R3: In xN mode the group index is k = subcol_i / N, so the low log2(N) sub-column bits are ignored. Output lane i (i < N) carries core set k*N+i. Core set j occupies `core_bus_i[j*16 +: 16]`, and output lane i occupies `lane_data_o[i*16 +: 16]`.
- R4: In x16 mode output lane i carries core set i whatever the value of `subcol_i`.
- R5: Every lane at or above the active width outputs all zeros.
- R6: A strobe on `rd_vld_i` at a clock edge gives the steered result and `out_vld_o` high one cycle later. Without a strobe, `out_vld_o` is low in the next cycle.
- R7: A cycle without `rd_vld_i` leaves `lane_data_o`, `lane_en_o` and `width_err_o` unchanged, whatever the other inputs do.
- R8: Width codes 3'b101 to 3'b111 are steered as x16 and set `width_err_o` with that result. The next strobed read with a legal code clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_vld_i | input | 1 | Read strobe; captures a steered result |
| width_sel_i | input | 3 | Active lane count code |
| subcol_i | input | 4 | Sub-column address below the column address |
| core_bus_i | input | 256 | Core read bus, 16 sets of 16 bits |
| lane_data_o | output | 256 | Registered lane data, 16 lanes of 16 bits |
| lane_en_o | output | 16 | Registered per-lane active flags |
| out_vld_o | output | 1 | Result valid, one cycle after the strobe |
| width_err_o | output | 1 | Registered illegal-width flag |

## Verification
The embedded properties check on every cycle that the valid flag follows the strobe by one cycle and that held outputs stay stable between strobes. They also check that inactive lanes are zero, that the enable vector is a contiguous run from lane 0, that an error result enables all lanes, and that x16 mode copies the core bus unchanged. The group arithmetic for the narrow modes is checked only by the bench. It restates the group index as a division and compares the full 256-bit output for several width and sub-column pairs. The bench also covers the reset values, the hold behaviour under changing inputs and the clearing of the error flag.

// File: rtl/rdlane_pkg.sv
package rdlane_pkg;

  localparam int unsigned CODE_W = 3;

  // Log2 of active lane count for a width code; illegal codes saturate to max.
  function automatic int unsigned code_log2(input logic [CODE_W-1:0] code,
                                            input int unsigned max_log);
    int unsigned c;
    c = int'(code);
    return (c > max_log) ? max_log : c;
  endfunction

  // Whether a width code is outside the legal set.
  function automatic logic code_bad(input logic [CODE_W-1:0] code,
                                    input int unsigned max_log);
    return int'(code) > max_log;
  endfunction

  // Source set for an output lane: aligned group base plus lane offset.
  function automatic int unsigned src_set(input int unsigned sc,
                                          input int unsigned lg,
                                          input int unsigned lane);
    return ((sc >> lg) << lg) | lane;
  endfunction

endpackage

// File: rtl/rdlane_decode.sv
module rdlane_decode
  import rdlane_pkg::*;
#(
  parameter int LANES = 16,
  localparam int LOG   = $clog2(LANES),
  localparam int LGW   = $clog2(LOG + 1)
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [LGW-1:0]    log_w_o,
  output logic [LANES-1:0]  lane_en_o,
  output logic              err_o
);

  int unsigned lg;

  always_comb begin
    lg      = code_log2(code_i, LOG);
    log_w_o = LGW'(lg);
    err_o   = code_bad(code_i, LOG);
    for (int i = 0; i < LANES; i++) begin
      lane_en_o[i] = (i < (1 << lg));
    end
  end

endmodule

// File: rtl/rdlane_mux.sv
module rdlane_mux
  import rdlane_pkg::*;
#(
  parameter int LANES     = 16,
  parameter int SLOT_BITS = 16,
  localparam int LOG      = $clog2(LANES),
  localparam int LGW      = $clog2(LOG + 1),
  localparam int BUS_W    = LANES * SLOT_BITS
) (
  input  logic [BUS_W-1:0] core_i,
  input  logic [LOG-1:0]   sc_i,
  input  logic [LGW-1:0]   log_w_i,
  input  logic [LANES-1:0] lane_en_i,
  output logic [BUS_W-1:0] steered_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LOG-1:0] sel;
    always_comb begin
      sel = LOG'(src_set(int'(sc_i), int'(log_w_i), g));
      steered_o[g*SLOT_BITS +: SLOT_BITS] =
        lane_en_i[g] ? core_i[sel*SLOT_BITS +: SLOT_BITS] : '0;
    end
  end

endmodule

// File: rtl/rdlane_steer.sv
module rdlane_steer
  import rdlane_pkg::*;
#(
  parameter int LANES     = 16,
  parameter int SLOT_BITS = 16,
  localparam int SC_W     = $clog2(LANES),
  localparam int LGW      = $clog2(SC_W + 1),
  localparam int BUS_W    = LANES * SLOT_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_vld_i,
  input  logic [CODE_W-1:0] width_sel_i,
  input  logic [SC_W-1:0]   subcol_i,
  input  logic [BUS_W-1:0]  core_bus_i,
  output logic [BUS_W-1:0]  lane_data_o,
  output logic [LANES-1:0]  lane_en_o,
  output logic              out_vld_o,
  output logic              width_err_o
);

  // Named internal events for the assertions
  logic [LGW-1:0]   log_w;
  logic [LANES-1:0] en_c;
  logic             err_c;
  logic [BUS_W-1:0] steered_c;
  logic             full_width_rd;

  assign full_width_rd = rd_vld_i && (width_sel_i == CODE_W'(SC_W));

  rdlane_decode #(.LANES(LANES)) u_decode (
    .code_i    (width_sel_i),
    .log_w_o   (log_w),
    .lane_en_o (en_c),
    .err_o     (err_c)
  );

  rdlane_mux #(.LANES(LANES), .SLOT_BITS(SLOT_BITS)) u_mux (
    .core_i    (core_bus_i),
    .sc_i      (subcol_i),
    .log_w_i   (log_w),
    .lane_en_i (en_c),
    .steered_o (steered_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane_data_o <= '0;
      lane_en_o   <= '0;
      out_vld_o   <= 1'b0;
      width_err_o <= 1'b0;
    end else begin
      out_vld_o <= rd_vld_i;
      if (rd_vld_i) begin
        lane_data_o <= steered_c;
        lane_en_o   <= en_c;
        width_err_o <= err_c;
      end
    end
  end

  AST_VLD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld_i |=> out_vld_o);                                   // R6
  AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_vld_i |=> !out_vld_o);                                 // R6
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_vld_i |=> ($stable(lane_data_o) && $stable(lane_en_o)
                   && $stable(width_err_o)));                  // R7
  AST_EN_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld_o |-> (lane_en_o[0] && ((lane_en_o & (lane_en_o + 1'b1)) == '0))); // R2
  AST_ERR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    width_err_o |-> (&lane_en_o));                             // R8
  AST_FULL_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    full_width_rd |=> (lane_data_o == $past(core_bus_i)));     // R4

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    AST_IDLE_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_en_o[g] |-> (lane_data_o[g*SLOT_BITS +: SLOT_BITS] == '0)); // R5
  end

endmodule

// File: tb/rdlane_steer_tb.sv
module rdlane_steer_tb_top;

  localparam int NV = 14;
  // Vector: {width[2:0], subcol[3:0], seed[7:0]}
  localparam logic [14:0] VEC [NV] = '{
    {3'd0, 4'd0,  8'h11}, {3'd0, 4'd7,  8'h22}, {3'd0, 4'd15, 8'h33},
    {3'd1, 4'd3,  8'h44}, {3'd1, 4'd10, 8'h55}, {3'd2, 4'd5,  8'h66},
    {3'd2, 4'd14, 8'h77}, {3'd3, 4'd9,  8'h88}, {3'd3, 4'd6,  8'h99},
    {3'd4, 4'd11, 8'hAA}, {3'd5, 4'd2,  8'hBB}, {3'd7, 4'd13, 8'hCC},
    {3'd2, 4'd0,  8'hDD}, {3'd3, 4'd1,  8'hEE}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rd_vld_i = 1'b0;
  logic [2:0]   width_sel_i = '0;
  logic [3:0]   subcol_i = '0;
  logic [255:0] core_bus_i = '0;
  logic [255:0] lane_data_o;
  logic [15:0]  lane_en_o;
  logic         out_vld_o;
  logic         width_err_o;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rdlane_steer dut_i (
    .clk(clk), .rst_n(rst_n), .rd_vld_i(rd_vld_i), .width_sel_i(width_sel_i),
    .subcol_i(subcol_i), .core_bus_i(core_bus_i), .lane_data_o(lane_data_o),
    .lane_en_o(lane_en_o), .out_vld_o(out_vld_o), .width_err_o(width_err_o)
  );

  function automatic logic [15:0] set_val(input int seed, input int j);
    return 16'((seed * 257) ^ (j * 16'h1111) ^ 16'h5A00);
  endfunction

  function automatic logic [255:0] mk_bus(input int seed);
    logic [255:0] b;
    for (int j = 0; j < 16; j++) b[j*16 +: 16] = set_val(seed, j);
    return b;
  endfunction

  function automatic int lanes_of(input logic [2:0] w);
    return (w <= 3'd4) ? (1 << w) : 16;
  endfunction

  function automatic logic [255:0] exp_data(input logic [2:0] w, input int sc, input int seed);
    logic [255:0] r;
    int n, k;
    n = lanes_of(w);
    k = sc / n;
    r = '0;
    for (int i = 0; i < n; i++) r[i*16 +: 16] = set_val(seed, k * n + i);
    return r;
  endfunction

  function automatic logic [15:0] exp_en(input logic [2:0] w);
    int n;
    n = lanes_of(w);
    return (n == 16) ? 16'hFFFF : 16'((1 << n) - 1);
  endfunction

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic [2:0] w, input logic [3:0] sc, input int seed);
    @(negedge clk);
    rd_vld_i    = v;
    width_sel_i = w;
    subcol_i    = sc;
    core_bus_i  = mk_bus(seed);
    @(posedge clk);
    @(negedge clk);
    rd_vld_i = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    errs++;
    checks++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    logic [255:0] held;
    logic [15:0]  held_en;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 vld", 256'(out_vld_o), 256'(0));
    chk("R1 err", 256'(width_err_o), 256'(0));
    chk("R1 en", 256'(lane_en_o), 256'(0));
    chk("R1 data", lane_data_o, 256'(0));
    rst_n = 1'b1;

    // Table walk: R2, R3, R5, R6, R8
    for (int v = 0; v < NV; v++) begin
      logic [2:0] w;
      logic [3:0] sc;
      int seed;
      w    = VEC[v][14:12];
      sc   = VEC[v][11:8];
      seed = int'(VEC[v][7:0]);
      apply(1'b1, w, sc, seed);
      chk("R6 vld", 256'(out_vld_o), 256'(1));
      chk("R2 en", 256'(lane_en_o), 256'(exp_en(w)));
      chk("R3/R5 data", lane_data_o, exp_data(w, int'(sc), seed));
      chk("R8 err", 256'(width_err_o), 256'(w > 3'd4));
    end

    // R4 x16 ignores subcol entirely
    apply(1'b1, 3'd4, 4'hF, 8'h3C);
    chk("R4 sc=F", lane_data_o, mk_bus(8'h3C));
    apply(1'b1, 3'd4, 4'h0, 8'h3C);
    chk("R4 sc=0", lane_data_o, mk_bus(8'h3C));

    // R5 x1 upper lanes zero
    apply(1'b1, 3'd0, 4'd9, 8'h5E);
    chk("R5 upper", lane_data_o[255:16], 255'(0) >> 15);
    chk("R3 x1 lane0", 256'(lane_data_o[15:0]), 256'(set_val(8'h5E, 9)));

    // R7 hold without strobe
    held = lane_data_o;
    held_en = lane_en_o;
    apply(1'b0, 3'd4, 4'd3, 8'h01);
    chk("R6 idle vld", 256'(out_vld_o), 256'(0));
    chk("R7 data", lane_data_o, held);
    chk("R7 en", 256'(lane_en_o), 256'(held_en));

    // R8 error set, held, then cleared
    apply(1'b1, 3'd6, 4'd4, 8'h42);
    chk("R8 set", 256'(width_err_o), 256'(1));
    chk("R8 x16 data", lane_data_o, mk_bus(8'h42));
    apply(1'b0, 3'd1, 4'd4, 8'h43);
    chk("R7 err held", 256'(width_err_o), 256'(1));
    apply(1'b1, 3'd1, 4'd4, 8'h43);
    chk("R8 clear", 256'(width_err_o), 256'(0));

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1 re-reset", lane_data_o, 256'(0));
    chk("R1 re-reset en", 256'(lane_en_o), 256'(0));
    finish_run();
  end

endmodule